// File: doc/BRIEF.md
# Grouped Power-Domain Sequencer

This block sequences the supply switch of one controller power domain that is shared by a group of invasion controllers, together with a separate processing-unit power domain for each element of the group. The shared controller domain wakes whenever any member is claimed or a neighbouring element that is invading the group asks for it. Each element's processing-unit domain is a child of the controller domain. It may start only after the controller domain is ready and while that element stays claimed.

Every domain follows the same ordered sequence. On power-up the switch closes and the domain stays isolated for a parameterised settle count. Isolation is then released, and one cycle later a ready flag tells the invasion logic that it may proceed. On power-down, isolation returns and ready drops in the same cycle, and the switch opens one cycle later. A request that arrives while isolation is back on but the switch is still closed cancels the power-down and starts a fresh settle. The shared domain pays its settle cost once for the whole group. Later members then pay only their own processing-unit settle.

Top module: `grp_pwr_seq`

## Requirements
- R1: After reset every switch enable is low, every isolation output is high and every ready output is low.
- R2: The controller switch enable rises at the first clock edge that samples any claimed member or the neighbour wake request.
- R3: After a domain's switch enable rises, isolation stays high for exactly its settle count (CTL_SETTLE or PU_SETTLE cycles) and is then released. Ready rises one cycle after that, so ready follows switch-on by settle+1 cycles.
- R4: A ready output is never high while that domain's isolation is high or its switch is off.
- R5: Processing-unit domain i switches on only when, in the previous cycle, the controller domain was ready and member i was claimed.
- R6: The controller domain stays on while any processing-unit domain is not fully off. On power-down, isolation rises and ready falls at the same edge, and the switch opens one edge later.
- R7: A wake request present while a domain is isolated for power-down keeps its switch closed and restarts the full settle, ending in ready settle+1 cycles later.
- R8: A request withdrawn during settle does not cut the sequence short: the domain still reaches ready and then powers down through isolation.
- R9: A member claimed while the shared controller domain is already ready reaches processing-unit ready PU_SETTLE+1 cycles after its claim is sampled.
- R10: The neighbour wake request alone powers the controller domain and leaves every processing-unit domain off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| claim_i | input | GROUP | Member i is claimed by an invasion (level) |
| nbr_wake_i | input | 1 | Wake request from an invading neighbour (level) |
| ctl_sw_en_o | output | 1 | Controller domain supply switch enable |
| ctl_iso_o | output | 1 | Controller domain isolation |
| ctl_ready_o | output | 1 | Controller domain powered and usable |
| pu_sw_en_o | output | GROUP | Per-element processing-unit switch enable |
| pu_iso_o | output | GROUP | Per-element processing-unit isolation |
| pu_ready_o | output | GROUP | Per-element processing-unit ready |

## Verification
The bench measures the cycle counts of the power-up path edge by edge. A design that releases isolation too early, or raises ready together with isolation release, shows up as a shifted release or ready cycle. The bench compares the overhead of the first member against a later member and against a one-member group. A design that gates the whole group per member, or that fails to share the controller settle, gives the wrong later-member latency. Re-claiming a member during the isolation step of power-down must keep the switch closed. A design that always completes the power-down would drop the switch for a cycle. A one-cycle claim pulse must still run the settle to ready and then power down. A design that aborts the settle early never shows ready.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [2:0] {
    PS_OFF,
    PS_SETTLE,
    PS_UNISO,
    PS_READY,
    PS_ISO
  } pstate_e;

  // cycles from the edge that enters settle to the edge that raises ready
  function automatic int wake_cycles(input int settle);
    return settle + 1;
  endfunction

endpackage

// File: rtl/pdseq_timer.sv
module pdseq_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CW'(LIMIT - 1));

  // settle counter never passes its limit (R3)
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < CW'(LIMIT)));

endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_i,
  output logic sw_o,
  output logic iso_o,
  output logic rdy_o,
  output logic idle_o
);
  pstate_e st_q, st_d;
  logic    settle_done;
  logic    ev_start;
  logic    ev_abort;
  logic [15:0] up_cnt_q;

  pdseq_timer #(.LIMIT(SETTLE)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (st_q == PS_SETTLE),
    .done_o (settle_done)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      PS_OFF:    if (want_i) st_d = PS_SETTLE;
      PS_SETTLE: if (settle_done) st_d = PS_UNISO;
      PS_UNISO:  st_d = PS_READY;
      PS_READY:  if (!want_i) st_d = PS_ISO;
      PS_ISO:    st_d = want_i ? PS_SETTLE : PS_OFF;
      default:   st_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_OFF;
    else        st_q <= st_d;
  end

  assign sw_o   = (st_q != PS_OFF);
  assign iso_o  = !(st_q == PS_UNISO || st_q == PS_READY);
  assign rdy_o  = (st_q == PS_READY);
  assign idle_o = (st_q == PS_OFF);

  // named events for the checks below
  assign ev_start = (st_d == PS_SETTLE) && (st_q != PS_SETTLE);
  assign ev_abort = (st_q == PS_ISO) && want_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      up_cnt_q <= '0;
    else if (ev_start)                               up_cnt_q <= '0;
    else if (st_q == PS_SETTLE || st_q == PS_UNISO)  up_cnt_q <= up_cnt_q + 1'b1;
  end

  p_rdy_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> (sw_o && !iso_o));

  p_iso_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_o) |-> iso_o);

  p_wake_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_o) |-> (up_cnt_q == 16'(wake_cycles(SETTLE))));

  p_iso_before_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_o) |-> $past(iso_o));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (sw_o && iso_o && !rdy_o));

endmodule

// File: rtl/pdseq_req.sv
module pdseq_req #(
  parameter int GROUP = 4
) (
  input  logic [GROUP-1:0] claim_i,
  input  logic             nbr_wake_i,
  input  logic [GROUP-1:0] pu_idle_i,
  input  logic             ctl_rdy_i,
  output logic             ctl_want_o,
  output logic [GROUP-1:0] pu_want_o
);
  assign ctl_want_o = (|claim_i) || nbr_wake_i || !(&pu_idle_i);
  assign pu_want_o  = claim_i & {GROUP{ctl_rdy_i}};
endmodule

// File: rtl/grp_pwr_seq.sv
module grp_pwr_seq #(
  parameter int GROUP      = 4,
  parameter int CTL_SETTLE = 6,
  parameter int PU_SETTLE  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GROUP-1:0] claim_i,
  input  logic             nbr_wake_i,
  output logic             ctl_sw_en_o,
  output logic             ctl_iso_o,
  output logic             ctl_ready_o,
  output logic [GROUP-1:0] pu_sw_en_o,
  output logic [GROUP-1:0] pu_iso_o,
  output logic [GROUP-1:0] pu_ready_o
);
  logic             ctl_want;
  logic             ctl_idle;
  logic [GROUP-1:0] pu_want;
  logic [GROUP-1:0] pu_idle;

  pdseq_req #(.GROUP(GROUP)) u_req (
    .claim_i    (claim_i),
    .nbr_wake_i (nbr_wake_i),
    .pu_idle_i  (pu_idle),
    .ctl_rdy_i  (ctl_ready_o),
    .ctl_want_o (ctl_want),
    .pu_want_o  (pu_want)
  );

  pdseq_fsm #(.SETTLE(CTL_SETTLE)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .want_i (ctl_want),
    .sw_o   (ctl_sw_en_o),
    .iso_o  (ctl_iso_o),
    .rdy_o  (ctl_ready_o),
    .idle_o (ctl_idle)
  );

  for (genvar i = 0; i < GROUP; i++) begin : g_pu
    pdseq_fsm #(.SETTLE(PU_SETTLE)) u_pu (
      .clk    (clk),
      .rst_n  (rst_n),
      .want_i (pu_want[i]),
      .sw_o   (pu_sw_en_o[i]),
      .iso_o  (pu_iso_o[i]),
      .rdy_o  (pu_ready_o[i]),
      .idle_o (pu_idle[i])
    );

    p_pu_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pu_sw_en_o[i]) |-> ($past(ctl_ready_o) && $past(claim_i[i])));
  end

  // a live child domain implies a powered parent (R6)
  p_hier_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|pu_sw_en_o) |-> (ctl_sw_en_o && !ctl_idle));

endmodule

// File: tb/grp_pwr_seq_bench.sv
module grp_pwr_seq_bench;
  localparam int G = 4;
  localparam int C = 6;
  localparam int P = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [G-1:0] claim = '0;
  logic nbr = 0;
  logic ctl_sw, ctl_iso, ctl_rdy;
  logic [G-1:0] pu_sw, pu_iso, pu_rdy;
  logic [0:0] s_claim = '0;
  logic s_sw, s_iso, s_rdy;
  logic [0:0] s_pu_sw, s_pu_iso, s_pu_rdy;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  grp_pwr_seq #(.GROUP(G), .CTL_SETTLE(C), .PU_SETTLE(P)) u_grp_pwr_seq (
    .clk(clk), .rst_n(rst_n), .claim_i(claim), .nbr_wake_i(nbr),
    .ctl_sw_en_o(ctl_sw), .ctl_iso_o(ctl_iso), .ctl_ready_o(ctl_rdy),
    .pu_sw_en_o(pu_sw), .pu_iso_o(pu_iso), .pu_ready_o(pu_rdy));

  grp_pwr_seq #(.GROUP(1), .CTL_SETTLE(C), .PU_SETTLE(P)) u_grp_pwr_seq_solo (
    .clk(clk), .rst_n(rst_n), .claim_i(s_claim), .nbr_wake_i(1'b0),
    .ctl_sw_en_o(s_sw), .ctl_iso_o(s_iso), .ctl_ready_o(s_rdy),
    .pu_sw_en_o(s_pu_sw), .pu_iso_o(s_pu_iso), .pu_ready_o(s_pu_rdy));

  // fields: claim[10:7] nbr[6] exp_sw[5] exp_rdy[4] exp_pu_rdy[3:0]
  localparam logic [10:0] VEC [7] = '{
    {4'b0001, 1'b0, 1'b1, 1'b1, 4'b0001},
    {4'b0011, 1'b0, 1'b1, 1'b1, 4'b0011},
    {4'b1010, 1'b0, 1'b1, 1'b1, 4'b1010},
    {4'b0000, 1'b1, 1'b1, 1'b1, 4'b0000},
    {4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'b1111, 1'b0, 1'b1, 1'b1, 4'b1111},
    {4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    int t_sw, t_iso, t_rdy, t_pu, t_solo, t_pu1, t_off, sw_gap, iso_at_sw;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctl_sw", ctl_sw, 0);
    check("R1 ctl_iso", ctl_iso, 1);
    check("R1 ctl_rdy", ctl_rdy, 0);
    check("R1 pu_iso", pu_iso, 4'hF);
    check("R1 pu_sw", pu_sw, 0);
    rst_n = 1;
    wait_n(2);
    check("R1 idle after release", {ctl_sw, pu_sw}, 0);

    // R2 R3 power-up timing, group of four against a group of one
    claim[0] = 1; s_claim[0] = 1;
    t_sw = -1; t_iso = -1; t_rdy = -1; t_pu = -1; t_solo = -1; iso_at_sw = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (t_sw < 0 && ctl_sw) begin t_sw = k; iso_at_sw = ctl_iso; end
      if (t_iso < 0 && !ctl_iso) t_iso = k;
      if (t_rdy < 0 && ctl_rdy) t_rdy = k;
      if (t_pu < 0 && pu_rdy[0]) t_pu = k;
      if (t_solo < 0 && s_pu_rdy[0]) t_solo = k;
    end
    check("R2 switch on first edge", t_sw, 1);
    check("R3 isolated at switch-on", iso_at_sw, 1);
    check("R3 isolation release", t_iso - t_sw, C);
    check("R3 ready after release", t_rdy - t_iso, 1);
    check("R5 pu ready after ctl ready", t_pu - t_rdy, P + 2);
    check("R3 solo first-member overhead", t_solo, C + P + 4);
    $display("overhead first member group4=%0d group1=%0d cycles", t_pu, t_solo);

    // R9 second member shares the ready controller domain
    claim[1] = 1;
    t_pu1 = -1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (t_pu1 < 0 && pu_rdy[1]) t_pu1 = k;
    end
    check("R9 later member overhead", t_pu1, P + 2);
    $display("overhead later member group4=%0d cycles", t_pu1);

    // R6 power-down ordering
    claim = '0; s_claim = '0;
    @(negedge clk);
    check("R6 pu iso n1", pu_iso[1:0], 2'b11);
    check("R6 pu sw n1", pu_sw[1:0], 2'b11);
    check("R6 ctl held n1", ctl_rdy, 1);
    @(negedge clk);
    check("R6 pu sw n2", pu_sw[1:0], 2'b00);
    check("R6 ctl held n2", ctl_rdy, 1);
    @(negedge clk);
    check("R6 ctl iso n3", {ctl_sw, ctl_iso, ctl_rdy}, 3'b110);
    @(negedge clk);
    check("R6 ctl off n4", ctl_sw, 0);
    wait_n(3);

    // R7 abort during isolation step
    claim[0] = 1;
    wait_n(30);
    claim[0] = 0;
    wait_n(3);
    check("R7 in isolation step", {ctl_sw, ctl_iso, ctl_rdy}, 3'b110);
    claim[0] = 1;
    sw_gap = 0; t_rdy = -1;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (!ctl_sw) sw_gap++;
      if (t_rdy < 0 && ctl_rdy) t_rdy = k;
    end
    check("R7 switch never opened", sw_gap, 0);
    check("R7 ready after restart", t_rdy, C + 2);
    claim = '0;
    wait_n(20);

    // R8 one-cycle claim pulse still completes settle
    claim[0] = 1;
    @(negedge clk);
    claim[0] = 0;
    sw_gap = 0; t_rdy = -1; t_off = -1; t_pu = 0;
    for (int k = 2; k <= 20; k++) begin
      @(negedge clk);
      if (k <= C + 2 && !ctl_sw) sw_gap++;
      if (t_rdy < 0 && ctl_rdy) t_rdy = k;
      if (t_off < 0 && !ctl_sw) t_off = k;
      if (pu_sw != 0) t_pu = 1;
    end
    check("R8 switch held through settle", sw_gap, 0);
    check("R8 ready reached", t_rdy, C + 2);
    check("R8 powered down after", t_off, C + 4);
    check("R8 no pu for withdrawn claim", t_pu, 0);

    // table walk: R5 R10 steady states
    foreach (VEC[v]) begin
      claim = VEC[v][10:7];
      nbr = VEC[v][6];
      wait_n(30);
      check($sformatf("R5 vec%0d ctl_sw", v), ctl_sw, VEC[v][5]);
      check($sformatf("R5 vec%0d ctl_rdy", v), ctl_rdy, VEC[v][4]);
      check($sformatf("R5 vec%0d pu_rdy", v), pu_rdy, VEC[v][3:0]);
      if (VEC[v][6]) check("R10 nbr wake leaves pu off", pu_sw, 0);
    end

    finish_run();
  end
endmodule